// File: doc/BRIEF.md
# Vertex Attribute Offset Calculator

This block lays out one interleaved vertex. It receives an ordered list of attribute type codes (4 bits each), the number of valid entries and a configured stride. After a start pulse it walks the list one entry per clock. Each entry is placed at the next offset that suits its alignment. The block then reports the byte offset of every entry and the total vertex size. When it finishes, it flags an error if the configured stride differs from that size.

A type code of 11 or below is a data attribute. Bits 1:0 select the element: 0 is a signed byte, 1 an unsigned byte, 2 a 16-bit value and 3 a 32-bit float. Bits 3:2 hold the component count minus one. Codes 12 to 15 are padding entries. A stride other than the natural vertex size can only be reached by adding padding entries to the list.

A separate path turns a vertex index into a byte address: the buffer base plus the index times the stride. The address appears one clock after an index strobe.

Top module: `vla_calc`

## Requirements
- R1: A data attribute starts at the first offset at or after the running position that is a multiple of its element size: 1 byte for element codes 0 and 1, 2 bytes for code 2, 4 bytes for code 3.
- R2: A data attribute occupies its element size times (bits 3:2 + 1) bytes, and the running position advances by that amount.
- R3: A padding code (12..15) starts at a multiple of 4 bytes and occupies 4, 8, 12 or 16 bytes (code 12, 13, 14, 15 respectively).
- R4: `vertex_size` equals the end of the last valid entry, with no rounding at the end.
- R5: `stride_err` is 1 exactly when the latched stride differs from `vertex_size`. It is valid from the `done` pulse and held until the next accepted start.
- R6: With N valid entries, `busy` is high while the walk runs. `done` is a one-cycle pulse seen N clock edges after the edge that samples `start`; when N is 0 it is seen right after that edge.
- R7: Offsets of entries at index N and above read 0. A count of 0 gives size 0. A count above the maximum is clamped to the maximum.
- R8: One clock after `idx_valid`, `vtx_addr` equals `buf_base + vtx_index * cfg_stride` (modulo 2^ADDR_W) and `addr_valid` is high. Without a strobe, `addr_valid` is low the next clock.
- R9: A `start` pulse while `busy` is ignored: the results of the running walk are unchanged.
- R10: After reset, `busy`, `done`, `stride_err`, `addr_valid`, `vertex_size`, `vtx_addr` and all offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| attr_count | input | CNT_W | Number of valid entries |
| attr_types | input | 4*MAX_ATTR | Type codes; entry i at bits 4i+3:4i |
| cfg_stride | input | OFS_W | Configured vertex stride in bytes |
| buf_base | input | ADDR_W | Buffer base address |
| idx_valid | input | 1 | Address request strobe |
| vtx_index | input | IDX_W | Vertex index |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the walk has finished |
| attr_offsets | output | OFS_W*MAX_ATTR | Byte offset of entry i at bits OFS_W*i +: OFS_W |
| vertex_size | output | OFS_W | Computed vertex size |
| stride_err | output | 1 | Stride mismatch flag |
| addr_valid | output | 1 | vtx_addr valid |
| vtx_addr | output | ADDR_W | Vertex base address |

## Verification
The assertions rely on a few properties of the inputs. Every entry placement is assumed to fit in OFS_W bits, so the running position never wraps; with the default widths, twelve maximal entries stay below 256. Entry placement is also assumed to grow strictly, which holds because no code has zero size. The bench draws codes from all 16 values and counts from 0 to 15. Counts above twelve exercise the clamp, while the offsets stay within the width. Strides are either the model's size or a random byte, so both outcomes of the mismatch flag are covered.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] attr_code_t;

  function automatic logic is_pad(attr_code_t c);
    return c > attr_code_t'(11);
  endfunction

  function automatic int unsigned elem_bytes(attr_code_t c);
    case (c[1:0])
      2'd2:    return 2;
      2'd3:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned align_bytes(attr_code_t c);
    return is_pad(c) ? 4 : elem_bytes(c);
  endfunction

  function automatic int unsigned span_bytes(attr_code_t c);
    if (is_pad(c)) return (int'(c[1:0]) + 1) * 4;
    return elem_bytes(c) * (int'(c[3:2]) + 1);
  endfunction
endpackage

// File: rtl/vla_step.sv
module vla_step
  import vla_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  attr_code_t       code,
  input  logic [OFS_W-1:0] pos,
  output logic [OFS_W-1:0] ofs,
  output logic [OFS_W-1:0] next_pos
);
  logic [OFS_W-1:0] al;
  logic [OFS_W-1:0] sp;

  always_comb begin
    al       = OFS_W'(align_bytes(code));
    sp       = OFS_W'(span_bytes(code));
    ofs      = (pos + al - OFS_W'(1)) & ~(al - OFS_W'(1));
    next_pos = ofs + sp;
  end
endmodule

// File: rtl/vla_walker.sv
module vla_walker
  import vla_pkg::*;
#(
  parameter int MAX_ATTR = 12,
  parameter int OFS_W    = 8,
  parameter int CNT_W    = $clog2(MAX_ATTR + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [CNT_W-1:0]          attr_count,
  input  logic [CODE_W*MAX_ATTR-1:0] attr_types,
  input  logic [OFS_W-1:0]          cfg_stride,
  output logic                      busy,
  output logic                      done,
  output logic [OFS_W*MAX_ATTR-1:0] attr_offsets,
  output logic [OFS_W-1:0]          vertex_size,
  output logic                      stride_err
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ATTR);

  attr_code_t       types_q [MAX_ATTR];
  logic [OFS_W-1:0] offs_q  [MAX_ATTR];
  logic [CNT_W-1:0] idx_q, cnt_q, cnt_clamp;
  logic [OFS_W-1:0] pos_q, stride_q;
  attr_code_t       cur_code;
  logic [OFS_W-1:0] step_ofs, step_next;
  logic             last_step;

  always_comb begin
    cnt_clamp = (attr_count > MAX_CNT) ? MAX_CNT : attr_count;
    cur_code  = types_q[idx_q];
    last_step = (idx_q == cnt_q - CNT_W'(1));
  end

  vla_step #(.OFS_W(OFS_W)) u_step (
    .code     (cur_code),
    .pos      (pos_q),
    .ofs      (step_ofs),
    .next_pos (step_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
      pos_q       <= '0;
      stride_q    <= '0;
      vertex_size <= '0;
      stride_err  <= 1'b0;
      for (int i = 0; i < MAX_ATTR; i++) begin
        types_q[i] <= '0;
        offs_q[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        stride_q <= cfg_stride;
        pos_q    <= '0;
        idx_q    <= '0;
        cnt_q    <= cnt_clamp;
        for (int i = 0; i < MAX_ATTR; i++) begin
          types_q[i] <= attr_types[CODE_W*i +: CODE_W];
          offs_q[i]  <= '0;
        end
        if (cnt_clamp == '0) begin
          done        <= 1'b1;
          vertex_size <= '0;
          stride_err  <= (cfg_stride != '0);
        end else begin
          busy       <= 1'b1;
          stride_err <= 1'b0;
        end
      end else if (busy) begin
        offs_q[idx_q] <= step_ofs;
        pos_q         <= step_next;
        idx_q         <= idx_q + CNT_W'(1);
        if (last_step) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          vertex_size <= step_next;
          stride_err  <= (stride_q != step_next);
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_ATTR; g++) begin : g_out
    assign attr_offsets[OFS_W*g +: OFS_W] = offs_q[g];
  end

  // R6: the done pulse only appears once the walk is idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1 / R3: every placement produced by the step logic is aligned
  p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((step_ofs & (OFS_W'(align_bytes(cur_code)) - OFS_W'(1))) == '0));

  // R2: placement never moves backwards and every entry has nonzero size
  p_grow_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step_ofs >= pos_q) && (step_next > step_ofs));

  // R9: a start seen while busy leaves the latched stride alone
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(stride_q));
endmodule

// File: rtl/vla_addr_gen.sv
module vla_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_valid,
  input  logic [IDX_W-1:0]  vtx_index,
  input  logic [OFS_W-1:0]  stride,
  input  logic [ADDR_W-1:0] buf_base,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] vtx_addr
);
  localparam int PROD_W = IDX_W + OFS_W;
  logic [PROD_W-1:0] prod;

  always_comb prod = PROD_W'(vtx_index) * PROD_W'(stride);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      vtx_addr   <= '0;
    end else begin
      addr_valid <= idx_valid;
      if (idx_valid) vtx_addr <= buf_base + ADDR_W'(prod);
    end
  end

  // R8: the valid flag follows the strobe by exactly one clock
  p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    idx_valid |=> addr_valid);
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !idx_valid |=> !addr_valid);
endmodule

// File: rtl/vla_calc.sv
module vla_calc #(
  parameter int MAX_ATTR = 12,
  parameter int OFS_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 16,
  parameter int CNT_W    = $clog2(MAX_ATTR + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [CNT_W-1:0]          attr_count,
  input  logic [4*MAX_ATTR-1:0]     attr_types,
  input  logic [OFS_W-1:0]          cfg_stride,
  input  logic [ADDR_W-1:0]         buf_base,
  input  logic                      idx_valid,
  input  logic [IDX_W-1:0]          vtx_index,
  output logic                      busy,
  output logic                      done,
  output logic [OFS_W*MAX_ATTR-1:0] attr_offsets,
  output logic [OFS_W-1:0]          vertex_size,
  output logic                      stride_err,
  output logic                      addr_valid,
  output logic [ADDR_W-1:0]         vtx_addr
);
  vla_walker #(.MAX_ATTR(MAX_ATTR), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_walker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .attr_count   (attr_count),
    .attr_types   (attr_types),
    .cfg_stride   (cfg_stride),
    .busy         (busy),
    .done         (done),
    .attr_offsets (attr_offsets),
    .vertex_size  (vertex_size),
    .stride_err   (stride_err)
  );

  vla_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .idx_valid  (idx_valid),
    .vtx_index  (vtx_index),
    .stride     (cfg_stride),
    .buf_base   (buf_base),
    .addr_valid (addr_valid),
    .vtx_addr   (vtx_addr)
  );
endmodule

// File: tb/tb_vla_calc.sv
module tb_vla_calc;
  localparam int MAX_ATTR = 12;
  localparam int OFS_W    = 8;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = 16;
  localparam int CNT_W    = 4;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      start = 1'b0;
  logic [CNT_W-1:0]          attr_count = '0;
  logic [4*MAX_ATTR-1:0]     attr_types = '0;
  logic [OFS_W-1:0]          cfg_stride = '0;
  logic [ADDR_W-1:0]         buf_base = '0;
  logic                      idx_valid = 1'b0;
  logic [IDX_W-1:0]          vtx_index = '0;
  logic                      busy, done, stride_err, addr_valid;
  logic [OFS_W*MAX_ATTR-1:0] attr_offsets;
  logic [OFS_W-1:0]          vertex_size;
  logic [ADDR_W-1:0]         vtx_addr;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  vla_calc #(.MAX_ATTR(MAX_ATTR), .OFS_W(OFS_W), .ADDR_W(ADDR_W),
             .IDX_W(IDX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .attr_count(attr_count),
    .attr_types(attr_types), .cfg_stride(cfg_stride), .buf_base(buf_base),
    .idx_valid(idx_valid), .vtx_index(vtx_index), .busy(busy), .done(done),
    .attr_offsets(attr_offsets), .vertex_size(vertex_size),
    .stride_err(stride_err), .addr_valid(addr_valid), .vtx_addr(vtx_addr)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic int m_align(int c);
    if (c > 11) return 4;
    case (c % 4) 2: return 2; 3: return 4; default: return 1; endcase
  endfunction
  function automatic int m_span(int c);
    if (c > 11) return ((c % 4) + 1) * 4;
    return m_align(c) * ((c / 4) + 1);
  endfunction

  int exp_ofs [MAX_ATTR];
  int exp_size;

  task automatic model(logic [4*MAX_ATTR-1:0] ty, int cnt);
    int p = 0;
    int n = (cnt > MAX_ATTR) ? MAX_ATTR : cnt;
    for (int i = 0; i < MAX_ATTR; i++) exp_ofs[i] = 0;
    for (int i = 0; i < n; i++) begin
      int c = int'(ty[4*i +: 4]);
      int a = m_align(c);
      p = ((p + a - 1) / a) * a;
      exp_ofs[i] = p;
      p = p + m_span(c);
    end
    exp_size = p;
  endtask

  // run one walk; glitch = pulse start again while busy with other codes
  task automatic walk(logic [4*MAX_ATTR-1:0] ty, int cnt, int stride, bit glitch);
    int k = 0;
    int n = (cnt > MAX_ATTR) ? MAX_ATTR : cnt;
    model(ty, cnt);
    @(negedge clk);
    attr_types = ty; attr_count = CNT_W'(cnt); cfg_stride = OFS_W'(stride);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && k < 40) begin
      if (glitch && k == 0) begin
        start = 1'b1; attr_types = ~ty; cfg_stride = OFS_W'(stride + 1);
      end else begin
        start = 1'b0;
      end
      if (n > 0) chk("R6 busy during walk", busy, 1);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk("R6 done latency", k, n);
    for (int i = 0; i < MAX_ATTR; i++) begin
      if (i >= n) chk("R7 unused offset", attr_offsets[OFS_W*i +: OFS_W], 0);
      else if (int'(ty[4*i +: 4]) > 11)
        chk("R3 padding offset", attr_offsets[OFS_W*i +: OFS_W], exp_ofs[i]);
      else chk("R1 data offset", attr_offsets[OFS_W*i +: OFS_W], exp_ofs[i]);
    end
    chk("R4 vertex size", vertex_size, exp_size);
    chk("R5 stride mismatch", stride_err, (stride % 256) != exp_size);
    if (glitch) chk("R9 restart ignored size", vertex_size, exp_size);
    @(negedge clk);
    chk("R6 done single cycle", done, 0);
    chk("R5 flag held", stride_err, (stride % 256) != exp_size);
  endtask

  function automatic logic [4*MAX_ATTR-1:0] pack2(int a, int b);
    logic [4*MAX_ATTR-1:0] v = '0;
    v[3:0] = 4'(a); v[7:4] = 4'(b);
    return v;
  endfunction

  task automatic addr_req(int base, int idx, int stride);
    longint unsigned e;
    @(negedge clk);
    buf_base = ADDR_W'(base); vtx_index = IDX_W'(idx);
    cfg_stride = OFS_W'(stride); idx_valid = 1'b1;
    e = (longint'(unsigned'(base)) + longint'(idx) * longint'(stride)) & 64'hFFFF_FFFF;
    @(negedge clk);
    idx_valid = 1'b0;
    chk("R8 addr valid", addr_valid, 1);
    chk("R8 address", vtx_addr, longint'(e));
    @(negedge clk);
    chk("R8 valid drops", addr_valid, 0);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 err", stride_err, 0);
    chk("R10 addr_valid", addr_valid, 0);
    chk("R10 size", vertex_size, 0);
    chk("R10 addr", vtx_addr, 0);
    chk("R10 offsets", attr_offsets == '0, 1);

    // directed: R1 byte then float -> 0,4 size 8
    walk(pack2(0, 3), 2, 8, 0);
    // R1 ubyte then 16-bit -> 0,2 size 4
    walk(pack2(1, 2), 2, 4, 0);
    // R3 byte then 4-byte pad -> 0,4 size 8; byte then 16-byte pad -> 0,4 size 20
    walk(pack2(0, 12), 2, 8, 0);
    walk(pack2(0, 15), 2, 20, 0);
    // R2 / R4: 3x16-bit (6 bytes) then byte -> 0,6 size 7, no end rounding
    walk(pack2(10, 0), 2, 7, 0);
    // R5 same list with padded stride -> mismatch
    walk(pack2(10, 0), 2, 8, 0);
    // R7 empty list, and clamp of an oversize count
    walk('0, 0, 0, 0);
    walk('0, 0, 4, 0);
    walk({12{4'd11}}, 15, 144, 0);
    // R9 restart while busy
    walk({12{4'd5}}, 6, 0, 1);

    // constrained random walks
    for (int r = 0; r < 40; r++) begin
      logic [4*MAX_ATTR-1:0] ty;
      int cnt, st;
      for (int i = 0; i < MAX_ATTR; i++) ty[4*i +: 4] = 4'($urandom_range(0, 15));
      cnt = $urandom_range(0, 15);
      model(ty, cnt);
      st = ($urandom_range(0, 1) == 1) ? exp_size : $urandom_range(0, 255);
      walk(ty, cnt, st, ($urandom_range(0, 3) == 0) && cnt > 0);
    end

    // R8 address generation
    addr_req(32'h1000, 0, 12);
    addr_req(32'hFFFF_FFF0, 3, 8);
    for (int r = 0; r < 20; r++)
      addr_req(int'($urandom), $urandom_range(0, 65535), $urandom_range(0, 255));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule